// File: doc/BRIEF.md
# Table-Lookup DDS Sine Generator

The block produces a sine carrier for a keyer that follows it. A phase register holds a whole table index plus a 16-bit fraction. On every clock the register advances by a run-time tuning word. The whole index selects one entry of a built-in sine table. That entry is then right-shifted by a selectable amount and registered as a signed sample.

The table holds 200 entries, which is not a power of two. The index therefore wraps by compare-and-subtract rather than by natural overflow. With a 50 MHz clock, a tuning word of integer step 4 and fraction 0 gives a 1 MHz carrier: 50 samples per period. Any other step from 1/65536 up to 199 entries per clock can be chosen, so the output frequency is set with fine resolution.

Top module: `dds_sine_gen`

## Requirements
- R1: While `rst_ni` is low, `wave_o` is 0 without waiting for a clock edge. The phase restarts at index 0 with fraction 0, so the first sample after release is entry 0.
- R2: `tune_i` bits [23:16] are the integer step and bits [15:0] are the fractional step. On each clock the fraction adds the fractional step, and its carry-out adds one extra entry to the index. A tuning word of 0 leaves the phase unchanged.
- R3: The index stays within 0..199. A sum of 200 or more is reduced by 200, so the phase is continuous across the table end.
- R4: An integer step of 200 or more is treated as 199.
- R5: `wave_o` after a clock edge is the attenuated table entry at the index held just before that edge, which is one register of latency.
- R6: Table entry k equals 511·sin(2πk/200), rounded, in 10-bit two's complement, within 1 LSB. Entry 50 is exactly +511 and entry 0 is 0.
- R7: `att_i` selects an arithmetic right shift of 0 to 3 bits on the table entry. It is sampled at the same edge as the index.
- R8: With `tune_i` = 0x040000 the output repeats every 50 clocks.
- R9: A change of `tune_i` takes effect from the next edge without resetting the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tune_i | input | 24 | Phase step: integer entries in [23:16], fraction in [15:0] |
| att_i | input | 2 | Output right-shift amount, 0 to 3 |
| wave_o | output | 10 | Signed sine sample |

## Verification
The bench builds the block with its defaults: a 200-entry table, a 16-bit fraction, a 10-bit output and a 2-bit attenuation control. The non-power-of-two depth makes the wrap-by-subtraction path reachable within a few clocks for large steps. The 16-bit fraction allows slow sub-entry steps whose carries are observable. All four shift amounts are reachable. Integer steps above 199 reach the clamp, because the 8-bit step field can exceed the table depth.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

  // Fixed-point sine for table entry k of a depth-entry period, scaled by amp.
  // Quarter-wave fold plus Taylor series in Q20, evaluated at elaboration.
  function automatic int sine_q(input int k, input int depth, input int amp);
    longint two_pi_q;
    longint x;
    longint term;
    longint acc;
    longint val;
    int     kk;
    int     qtr;
    int     half;
    bit     neg;
    two_pi_q = 64'd6588397;
    qtr  = depth / 4;
    half = depth / 2;
    kk   = k;
    neg  = 1'b0;
    if (kk >= half) begin
      kk  = kk - half;
      neg = 1'b1;
    end
    if (kk > qtr) kk = half - kk;
    x    = (longint'(kk) * two_pi_q) / longint'(depth);
    term = x;
    acc  = x;
    for (int n = 1; n <= 6; n++) begin
      term = (term * x) >>> 20;
      term = (term * x) >>> 20;
      term = -term / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    val = (acc * longint'(amp) + 64'sd524288) >>> 20;
    if (val > longint'(amp)) val = longint'(amp);
    return neg ? -int'(val) : int'(val);
  endfunction

endpackage

// File: rtl/dds_sine_rom.sv
`timescale 1ns/1ps
module dds_sine_rom #(
  parameter int DEPTH = 200,
  parameter int IDX_W = 8,
  parameter int OUT_W = 10
) (
  input  logic [IDX_W-1:0]        idx_i,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam int AMP = 2 ** (OUT_W - 1) - 1;
  localparam logic [IDX_W:0] DEPTH_W = (IDX_W + 1)'(DEPTH);

  logic signed [OUT_W-1:0] tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    localparam int V = dds_pkg::sine_q(g, DEPTH, AMP);
    assign tab[g] = OUT_W'(V);
  end

  always_comb begin
    if ({1'b0, idx_i} < DEPTH_W) sample_o = tab[idx_i];
    else                         sample_o = '0;
  end
endmodule

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter int DEPTH  = 200,
  parameter int IDX_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  step_int_i,
  input  logic [FRAC_W-1:0] step_frac_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam logic [IDX_W:0] DEPTH_W  = (IDX_W + 1)'(DEPTH);
  localparam logic [IDX_W:0] MAX_STEP = (IDX_W + 1)'(DEPTH - 1);

  logic [IDX_W:0]  step_c;
  logic [FRAC_W:0] frac_sum;
  logic [IDX_W:0]  idx_sum;
  logic [IDX_W:0]  idx_wrap;

  always_comb begin
    step_c   = ({1'b0, step_int_i} >= DEPTH_W) ? MAX_STEP : {1'b0, step_int_i};
    frac_sum = {1'b0, frac_o} + {1'b0, step_frac_i};
    idx_sum  = {1'b0, idx_o} + step_c + {{IDX_W{1'b0}}, frac_sum[FRAC_W]};
    // single subtract suffices: sum < 2*DEPTH
    idx_wrap = (idx_sum >= DEPTH_W) ? (idx_sum - DEPTH_W) : idx_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      frac_o <= '0;
    end else begin
      idx_o  <= idx_wrap[IDX_W-1:0];
      frac_o <= frac_sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/dds_out_stage.sv
`timescale 1ns/1ps
module dds_out_stage #(
  parameter int OUT_W = 10,
  parameter int ATT_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [OUT_W-1:0] sample_i,
  input  logic [ATT_W-1:0]        att_i,
  output logic signed [OUT_W-1:0] wave_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_o <= '0;
    else         wave_o <= sample_i >>> att_i;
  end
endmodule

// File: rtl/dds_sine_gen.sv
`timescale 1ns/1ps
module dds_sine_gen #(
  parameter int TBL_DEPTH = 200,
  parameter int FRAC_W    = 16,
  parameter int OUT_W     = 10,
  parameter int ATT_W     = 2,
  parameter int IDX_W     = $clog2(TBL_DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [IDX_W+FRAC_W-1:0]   tune_i,
  input  logic [ATT_W-1:0]          att_i,
  output logic signed [OUT_W-1:0]   wave_o
);
  logic [IDX_W-1:0]        phase_idx;
  logic [FRAC_W-1:0]       phase_frac;
  logic signed [OUT_W-1:0] rom_sample;

  dds_phase_acc #(
    .DEPTH (TBL_DEPTH),
    .IDX_W (IDX_W),
    .FRAC_W(FRAC_W)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_int_i (tune_i[IDX_W+FRAC_W-1:FRAC_W]),
    .step_frac_i(tune_i[FRAC_W-1:0]),
    .idx_o      (phase_idx),
    .frac_o     (phase_frac)
  );

  dds_sine_rom #(
    .DEPTH(TBL_DEPTH),
    .IDX_W(IDX_W),
    .OUT_W(OUT_W)
  ) u_rom (
    .idx_i   (phase_idx),
    .sample_o(rom_sample)
  );

  dds_out_stage #(
    .OUT_W(OUT_W),
    .ATT_W(ATT_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(rom_sample),
    .att_i   (att_i),
    .wave_o  (wave_o)
  );
endmodule

// File: rtl/dds_sine_chk.sv
`timescale 1ns/1ps
module dds_sine_chk #(
  parameter int TBL_DEPTH = 200,
  parameter int FRAC_W    = 16,
  parameter int OUT_W     = 10,
  parameter int ATT_W     = 2,
  parameter int IDX_W     = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [IDX_W+FRAC_W-1:0] tune_i,
  input logic [ATT_W-1:0]        att_i,
  input logic signed [OUT_W-1:0] wave_o,
  input logic [IDX_W-1:0]        idx_i,
  input logic [FRAC_W-1:0]       frac_i
);
  localparam int PEAK = 2 ** (OUT_W - 1) - 1;
  localparam int QTR  = TBL_DEPTH / 4;

  // R1: output held at zero while reset is applied
  a_r1_reset_zero: assert property (@(posedge clk_i) !rst_ni |-> wave_o == '0);

  a_r3_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_i) < TBL_DEPTH);

  // R2: zero tuning word freezes the phase
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_i == '0 |=> $stable(idx_i) && $stable(frac_i));

  // R5/R6: index 0 gives a zero sample one edge later
  a_r5_idx0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_i) == 0 |=> wave_o == '0);

  a_r6_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_i) == QTR |=> int'(wave_o) == (PEAK >>> int'($past(att_i))));

  a_r7_att_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (int'(wave_o) <= (PEAK >>> int'($past(att_i)))) &&
             (int'(wave_o) >= -(PEAK >>> int'($past(att_i))) - 1));
endmodule

bind dds_sine_gen dds_sine_chk #(
  .TBL_DEPTH(TBL_DEPTH),
  .FRAC_W   (FRAC_W),
  .OUT_W    (OUT_W),
  .ATT_W    (ATT_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tune_i(tune_i),
  .att_i (att_i),
  .wave_o(wave_o),
  .idx_i (phase_idx),
  .frac_i(phase_frac)
);

// File: tb/sim_dds_sine_gen.sv
`timescale 1ns/1ps
module sim_dds_sine_gen;
  localparam int CLK_PERIOD = 20;
  localparam int DEPTH = 200;
  localparam int AMP   = 511;
  localparam longint FULL = 64'd200 * 64'd65536;

  typedef struct {
    int    exp_v;
    string tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [23:0]       tune = '0;
  logic [1:0]        att = '0;
  logic signed [9:0] wave;

  item_t  sb[$];
  longint ph = 0;
  int     total = 0;
  int     bad = 0;
  bit     done = 1'b0;

  dds_sine_gen u0 (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .tune_i(tune),
    .att_i (att),
    .wave_o(wave)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int ref_entry(input int k);
    real v;
    v = real'(AMP) * $sin(2.0 * 3.14159265358979 * real'(k) / real'(DEPTH));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit near(input int a, input int b);
    return (a - b <= 1) && (b - a <= 1);
  endfunction

  // apply inputs, queue the sample the next edge must produce, advance model
  task automatic drive(input logic [23:0] tw, input logic [1:0] sh, input string tag);
    item_t  it;
    longint step;
    tune = tw;
    att  = sh;
    it.exp_v = ref_entry(int'(ph / 65536)) >>> int'(sh);
    it.tag   = tag;
    sb.push_back(it);
    step = longint'(tw[23:16]);
    if (step >= DEPTH) step = DEPTH - 1;
    ph = (ph + step * 65536 + longint'(tw[15:0])) % FULL;
  endtask

  task automatic step_n(input int n, input logic [23:0] tw, input logic [1:0] sh,
                        input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(tw, sh, tag);
    end
  endtask

  task automatic do_reset(input logic [23:0] tw, input logic [1:0] sh);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(wave == '0, "R1 async clear", int'(wave), 0);
    sb.delete();
    ph = 0;
    repeat (2) @(negedge clk);
    chk(wave == '0, "R1 held", int'(wave), 0);
    rst_ni = 1'b1;
    drive(tw, sh, "R1 restart");
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    item_t it;
    #2;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      chk(near(int'(wave), it.exp_v), it.tag, int'(wave), it.exp_v);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a;
    int b;
    #(CLK_PERIOD * 3 + 3);
    chk(wave == '0, "R1 reset state", int'(wave), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(24'h040000, 2'd0, "R5 1MHz");
    step_n(120, 24'h040000, 2'd0, "R6 R5 1MHz");

    // R8: period of 50 clocks
    @(posedge clk);
    #5;
    a = int'(wave);
    step_n(50, 24'h040000, 2'd0, "R8 period");
    @(posedge clk);
    #5;
    b = int'(wave);
    chk(a == b, "R8 repeat", b, a);

    // R2: fractional steps and carries
    step_n(300, 24'h034000, 2'd1, "R2 frac 3.25");
    step_n(200, 24'h00C000, 2'd0, "R2 frac 0.75");
    step_n(20, 24'h000000, 2'd2, "R2 zero step");

    // R3: wrap with steps near the table size
    do_reset(24'h960000, 2'd0);
    step_n(40, 24'h960000, 2'd0, "R3 step 150");
    step_n(60, 24'hC7FFFF, 2'd0, "R3 step 199.99");

    // R4: integer steps above depth clamp to 199
    step_n(40, 24'hFA0000, 2'd0, "R4 step 250");
    step_n(40, 24'hC80000, 2'd3, "R4 step 200");

    // R7: every shift amount
    for (int s = 0; s < 4; s++) step_n(55, 24'h028000, 2'(s), "R7 shift");

    // R9: retune without phase reset
    step_n(7, 24'h050000, 2'd0, "R9 before");
    step_n(30, 24'h0B2000, 2'd0, "R9 after");

    // R1: reset mid-run restarts phase
    do_reset(24'h040000, 2'd0);
    step_n(60, 24'h040000, 2'd1, "R1 R5 after reset");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule